// File: doc/BRIEF.md
# Per-Channel White Balance Lookup

This block remaps the red, green and blue components of a streaming pixel bus, one pixel per clock. Each colour has its own 256-entry table of 8-bit values, indexed by that colour's input value. The result is registered, so the output follows the input by one clock. Valid and the two sync signals are delayed by the same amount.

A host loads the tables through a simple write port. Each write carries a page (0 red, 1 green, 2 blue), an entry address and a data byte. There is no read path.

After reset the tables must be filled in a fixed order: red, then green, then blue. Each page must have every entry written before the next page is accepted. Once blue is complete the block locks, and later writes are dropped. A reload-enable input opens the tables again while the lookup stays in use. Reload writes go to a shadow copy and take effect together, at a frame boundary, after a commit strobe.

Top module: `wbal_lut`

## Requirements
- R1: With the lookup active, each output component equals the table entry of its own colour at the input value, one clock after the input. `out_valid`, `out_hsync` and `out_vsync` repeat their inputs with the same one-clock delay.
- R2: While `bal_en` is low, or before the initial load has finished, `out_pix` equals `in_pix` of the previous clock.
- R3: After reset the load must fill page 0 (red) first, then page 1 (green), then page 2 (blue). A page counts as complete once each of its 256 addresses has been written at least once. `init_done` rises on the clock that takes the last missing blue entry and stays high until reset.
- R4: During the initial load, a write to any page other than the one being filled (including page 3) is discarded. It sets `order_err`, which stays high until reset.
- R5: After `init_done`, writes made while `reload_en` is low change no table value seen at the output, even after a commit and a frame boundary.
- R6: While `reload_en` is high, writes go to a shadow copy. The output keeps the old values until a `cfg_commit` pulse has been seen and the next rising edge of `in_vsync` arrives; a frame boundary with no commit pending changes nothing. Within four clocks of that edge, when no host write is under way, all pending entries switch together.
- R7: A reload may touch any subset of entries. Entries not written keep their current values across the switch, and an entry can be reloaded again after a switch.
- R8: With `narrow_in` high, a component's top six bits select the entry: the index is bits [7:2] of the input followed by two zero bits. Only entries 0, 4, 8, …, 252 are used.
- R9: With `narrow_out` high, the looked-up value is reduced to six bits: bits [7:2] of the entry followed by two zero bits. With it low, all eight bits are passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Host write strobe |
| cfg_page | input | 2 | Table select: 0 red, 1 green, 2 blue |
| cfg_addr | input | 8 | Table entry address |
| cfg_data | input | 8 | Entry value |
| cfg_commit | input | 1 | Request a switch to reloaded contents at the next frame boundary |
| bal_en | input | 1 | Lookup enable |
| reload_en | input | 1 | Allow writes after the initial load |
| narrow_in | input | 1 | Input components carry 6 significant bits |
| narrow_out | input | 1 | Reduce results to 6 significant bits |
| in_valid | input | 1 | Input pixel valid |
| in_hsync | input | 1 | Input line sync |
| in_vsync | input | 1 | Input frame sync; its rising edge is the frame boundary |
| in_pix | input | 24 | Input pixel: red [7:0], green [15:8], blue [23:16] |
| out_valid | output | 1 | Delayed valid |
| out_hsync | output | 1 | Delayed line sync |
| out_vsync | output | 1 | Delayed frame sync |
| out_pix | output | 24 | Output pixel, same packing as the input |
| init_done | output | 1 | Initial load complete |
| order_err | output | 1 | Sticky flag: out-of-order write during the initial load |

## Verification
The assertions assume reset is held for at least one clock at start-up. They also assume the host does not raise `cfg_we` with reload enabled on every clock of a frame boundary, since a switch only happens on a clock with no reload write. The stimulus drives host writes, pixels and frame pulses in separate windows. Each sync pulse lasts three clocks, with no pixels or writes during it, so the switch lands inside the pulse. Expected pixels come from a table model in the bench that changes only when a commit has been followed by a pulse.

// File: rtl/wbal_lut.sv
module wbal_lut #(
  parameter int DW     = 8,
  parameter int NCH    = 3,
  parameter int NARROW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_page,
  input  logic [DW-1:0]     cfg_addr,
  input  logic [DW-1:0]     cfg_data,
  input  logic              cfg_commit,
  input  logic              bal_en,
  input  logic              reload_en,
  input  logic              narrow_in,
  input  logic              narrow_out,
  input  logic              in_valid,
  input  logic              in_hsync,
  input  logic              in_vsync,
  input  logic [NCH*DW-1:0] in_pix,
  output logic              out_valid,
  output logic              out_hsync,
  output logic              out_vsync,
  output logic [NCH*DW-1:0] out_pix,
  output logic              init_done,
  output logic              order_err
);
  localparam int DEPTH = 1 << DW;
  localparam int NENT  = NCH * DEPTH;
  localparam int EW    = $clog2(NENT);
  localparam int DROP  = DW - NARROW;

  logic [DW-1:0]   bank0 [NENT];
  logic [DW-1:0]   bank1 [NENT];
  logic [NENT-1:0] sel, pend, pend_nxt, fill_bit;
  logic [1:0]      cur_page;
  logic            commit_req, swap_arm, vs_d;
  logic [EW-1:0]   wr_ent;
  logic            page_ok, init_hit, init_bad, rl_wr, page_full, swap_go, vs_rise, use_lut;
  logic [NCH*DW-1:0] nxt_pix;

  assign wr_ent    = EW'(int'(cfg_page) * DEPTH) + EW'(cfg_addr);
  assign page_ok   = int'(cfg_page) < NCH;
  assign init_hit  = cfg_we && !init_done && cfg_page == cur_page;
  assign init_bad  = cfg_we && !init_done && cfg_page != cur_page;
  assign rl_wr     = cfg_we && init_done && reload_en && page_ok;
  assign fill_bit  = init_hit ? (NENT'(1) << wr_ent) : '0;
  assign pend_nxt  = pend | fill_bit;
  assign page_full = &pend_nxt[int'(cur_page)*DEPTH +: DEPTH];
  assign vs_rise   = in_vsync && !vs_d;
  assign swap_go   = swap_arm && !rl_wr;
  assign use_lut   = bal_en && init_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel        <= '0;
      pend       <= '0;
      cur_page   <= '0;
      init_done  <= 1'b0;
      order_err  <= 1'b0;
      commit_req <= 1'b0;
      swap_arm   <= 1'b0;
      vs_d       <= 1'b0;
    end else begin
      vs_d <= in_vsync;
      if (init_bad) order_err <= 1'b1;
      if (!init_done) begin
        pend <= pend_nxt;
        if (init_hit && page_full) begin
          if (int'(cur_page) == NCH - 1) begin
            init_done <= 1'b1;
            pend      <= '0;
          end else begin
            cur_page <= cur_page + 2'd1;
          end
        end
      end else if (swap_go) begin
        sel      <= sel ^ pend;
        pend     <= '0;
        swap_arm <= 1'b0;
      end else if (rl_wr) begin
        pend[wr_ent] <= 1'b1;
      end
      if (vs_rise && commit_req) begin
        swap_arm   <= 1'b1;
        commit_req <= cfg_commit;
      end else if (cfg_commit && init_done) begin
        commit_req <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (init_hit) bank0[wr_ent] <= cfg_data;
    if (rl_wr) begin
      if (sel[wr_ent]) bank0[wr_ent] <= cfg_data;
      else             bank1[wr_ent] <= cfg_data;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0] px, idx, ent, mapped;
    logic [EW-1:0] rd;
    assign px     = in_pix[c*DW +: DW];
    assign idx    = narrow_in ? {px[DW-1:DROP], {DROP{1'b0}}} : px;
    assign rd     = EW'(c * DEPTH) + EW'(idx);
    assign ent    = sel[rd] ? bank1[rd] : bank0[rd];
    assign mapped = narrow_out ? {ent[DW-1:DROP], {DROP{1'b0}}} : ent;
    assign nxt_pix[c*DW +: DW] = use_lut ? mapped : px;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hsync <= 1'b0;
      out_vsync <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= in_valid;
      out_hsync <= in_hsync;
      out_vsync <= in_vsync;
      out_pix   <= nxt_pix;
    end
  end

  a_r1_valid_on: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_valid_off: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r1_vsync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    in_vsync |=> out_vsync);
  a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !(bal_en && init_done) |=> out_pix == $past(in_pix));
  a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  a_r4_bad_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !init_done && cfg_page != cur_page) |=> order_err);
  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    order_err |=> order_err);
  a_r5_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && cfg_we && !reload_en && !swap_arm) |=> $stable(pend) && $stable(sel));
  a_r6_no_early_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !swap_arm) |=> $stable(sel));
endmodule

// File: tb/wbal_lut_test.sv
module wbal_lut_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_commit = 0, bal_en = 0, reload_en = 0, narrow_in = 0, narrow_out = 0;
  logic [1:0] cfg_page = 0;
  logic [7:0] cfg_addr = 0, cfg_data = 0;
  logic in_valid = 0, in_hsync = 0, in_vsync = 0;
  logic [23:0] in_pix = 0;
  logic out_valid, out_hsync, out_vsync, init_done, order_err;
  logic [23:0] out_pix;

  int tests = 0, fails = 0;
  typedef struct { logic [24:0] v; string tag; } item_t;
  item_t sbq[$];
  logic [7:0] m  [3][256];
  logic [7:0] pm [3][256];
  bit         pv [3][256];
  bit model_en = 0, model_done = 0, commit_pend = 0;

  always #2 clk = ~clk;

  wbal_lut uut (.clk, .rst_n, .cfg_we, .cfg_page, .cfg_addr, .cfg_data, .cfg_commit,
    .bal_en, .reload_en, .narrow_in, .narrow_out, .in_valid, .in_hsync, .in_vsync,
    .in_pix, .out_valid, .out_hsync, .out_vsync, .out_pix, .init_done, .order_err);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expc(int c, logic [7:0] v);
    logic [7:0] idx, e;
    if (!(model_en && model_done)) return v;
    idx = narrow_in ? {v[7:2], 2'b00} : v;
    e = m[c][idx];
    return narrow_out ? {e[7:2], 2'b00} : e;
  endfunction

  function automatic logic [7:0] f0(int c, int a);
    return 8'((a * 7 + c * 50 + 3) & 255);
  endfunction

  task automatic wr(input logic [1:0] p, input logic [7:0] a, input logic [7:0] d);
    cfg_we = 1; cfg_page = p; cfg_addr = a; cfg_data = d;
    if (model_done && reload_en && p < 3) begin pm[p][a] = d; pv[p][a] = 1; end
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic px(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                    input logic hs, input string tag);
    item_t it;
    in_valid = 1; in_hsync = hs; in_pix = {b, g, r};
    it.v = {hs, expc(2, b), expc(1, g), expc(0, r)};
    it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    in_valid = 0; in_hsync = 0;
  endtask

  task automatic commit();
    cfg_commit = 1; @(negedge clk); cfg_commit = 0;
    if (model_done) commit_pend = 1;
  endtask

  task automatic vpulse();
    in_vsync = 1;
    @(negedge clk);
    check(out_vsync == 1'b1, "R1 vsync delay", 32'(out_vsync), 1);
    repeat (2) @(negedge clk);
    in_vsync = 0;
    @(negedge clk);
    if (commit_pend) begin
      for (int c = 0; c < 3; c++)
        for (int a = 0; a < 256; a++)
          if (pv[c][a]) begin m[c][a] = pm[c][a]; pv[c][a] = 0; end
      commit_pend = 0;
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && out_valid) begin
      if (sbq.size() == 0) check(0, "R1 unexpected output", 32'(out_pix), 0);
      else begin
        item_t e;
        e = sbq.pop_front();
        check({out_hsync, out_pix} == e.v, e.tag, 32'({out_hsync, out_pix}), 32'(e.v));
      end
    end
  end

  initial begin
    #(4 * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 3; c++)
      for (int a = 0; a < 256; a++) begin m[c][a] = f0(c, a); pv[c][a] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 0 && init_done == 0 && order_err == 0, "R3 reset state",
          32'({out_valid, init_done, order_err}), 0);

    bal_en = 1; model_en = 1;
    px(8'h12, 8'h34, 8'h56, 1, "R2 pass before load");
    px(8'hff, 8'h00, 8'h81, 0, "R2 pass before load");

    wr(2, 8'd5, 8'haa);
    check(order_err == 1, "R4 out-of-order flag", 32'(order_err), 1);
    for (int a = 0; a < 256; a++) wr(0, 8'(a), f0(0, a));
    wr(0, 8'd10, 8'hee);
    check(order_err == 1, "R4 sticky flag", 32'(order_err), 1);
    for (int a = 0; a < 128; a++) wr(1, 8'(a), f0(1, a));
    check(init_done == 0, "R3 partial load not done", 32'(init_done), 0);
    for (int a = 128; a < 256; a++) wr(1, 8'(a), f0(1, a));
    for (int a = 255; a >= 1; a--) wr(2, 8'(a), f0(2, a));
    check(init_done == 0, "R3 blue entry 0 missing", 32'(init_done), 0);
    wr(2, 8'd0, f0(2, 0));
    check(init_done == 1, "R3 done after blue", 32'(init_done), 1);
    model_done = 1;

    px(8'd10, 8'd10, 8'd10, 0, "R4 discarded write left red 10");
    px(8'd0, 8'd255, 8'd128, 1, "R1 lookup");
    px(8'd255, 8'd0, 8'd5, 0, "R1 lookup");
    for (int i = 0; i < 6; i++) px(8'(i * 41), 8'(i * 13 + 1), 8'(250 - i), 1'(i), "R1 lookup sweep");

    narrow_in = 1;
    px(8'h37, 8'hfe, 8'h01, 0, "R8 narrow index");
    narrow_out = 1;
    px(8'h37, 8'h9b, 8'hfc, 0, "R8 R9 narrow both");
    narrow_in = 0;
    px(8'h13, 8'h77, 8'hff, 1, "R9 narrow result");
    narrow_out = 0;

    wr(0, 8'd20, 8'h00);
    commit();
    vpulse();
    px(8'd20, 8'd20, 8'd20, 0, "R5 locked write ignored");

    reload_en = 1;
    wr(0, 8'd30, 8'h5a);
    wr(1, 8'd31, 8'hc3);
    px(8'd30, 8'd31, 8'd0, 0, "R6 old until commit");
    vpulse();
    px(8'd30, 8'd31, 8'd0, 0, "R6 no switch without commit");
    commit();
    px(8'd30, 8'd31, 8'd0, 0, "R6 old until frame edge");
    vpulse();
    px(8'd30, 8'd31, 8'd0, 0, "R6 new after switch");
    px(8'd31, 8'd30, 8'd30, 1, "R7 untouched entries kept");
    wr(0, 8'd30, 8'h11);
    commit();
    vpulse();
    px(8'd30, 8'd31, 8'd77, 0, "R7 second reload of entry");

    bal_en = 0; model_en = 0;
    px(8'd30, 8'd31, 8'd77, 1, "R2 bypass when disabled");
    repeat (3) @(negedge clk);
    check(sbq.size() == 0, "R1 all outputs seen", 32'(sbq.size()), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule